// File: doc/BRIEF.md
# LVDS Transmitter Analog Bring-Up Sequencer

This block powers up the analog front end of an LVDS transmitter without software stepping through the procedure. A one-cycle start pulse launches a fixed list of seven accesses to two 32-bit control words. The block reaches those words through a small register-bus master. Each access uses an address, a write strobe and a full-word data value, and is held until the slave signals ready. Reads serve only as the first half of read-modify-write updates, and those updates can only set bits.

The sequence runs in this order:

1. A full write loads the bias and regulator settings into the first control word, `CFG_A`.
2. The block waits for a long settling interval.
3. The block sets two five-bit groups in the second control word, `CFG_B`.
4. The block waits for a short interval.
5. The block sets two more five-bit groups in `CFG_B`.
6. The block sets the main-bias enable bit in `CFG_A` again as the last access.

Both wait lengths are given in nanoseconds. At elaboration they are converted to core-clock cycles from a clock-frequency parameter and rounded up, with one cycle of margin added. A `busy` flag covers the whole run. A `done` flag rises when the final write lands and stays high until the next accepted start.

Top module: `lvds_phy_bringup`

## Requirements
- R1: A start pulse while idle is accepted: `busy` is high from the next cycle, `done` falls, and the first bus request is a write to `CFG_A` at offset 0x220.
- R2: The first access writes the full word 0x3F71_0000 to `CFG_A`. This word has bits 16, 20-22 and 24-29 set and every other bit clear.
- R3: At least 1200 ns elapse between the completion of the first write and the request that follows it. That request is a read of `CFG_B` at offset 0x224.
- R4: The next write to `CFG_B` carries the value just read, ORed with 0x7C00_7C00 (bits 30:26 and 14:10).
- R5: At least 120 ns elapse between the completion of that write and the next request, which is again a read of `CFG_B`.
- R6: The following write to `CFG_B` carries the value just read, ORed with 0x001F_001F (bits 20:16 and 4:0).
- R7: The sequence ends with a read of `CFG_A` followed by a write of that value ORed with 0x0040_0000 (bit 22). The run has exactly seven accesses.
- R8: A request holds its address, direction and data unchanged until ready is seen. A transfer completes on a clock edge where request and ready are both high, and the request is low in the following cycle.
- R9: `done` rises one cycle after the final write completes and `busy` falls at the same time. `done` stays high until the next accepted start, and `done` and `busy` are never high together.
- R10: A start pulse while `busy` is high is ignored: the order and data of the accesses are unaffected and no second run follows.
- R11: A synchronous reset, including one in the middle of a run, returns the block to idle with `busy`, `done` and the bus request all low. The block stays idle until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that launches the bring-up |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | High after a completed run until the next accepted start |
| bus_req_o | output | 1 | Bus request, held until `bus_ready_i` |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte offset of the target control word |
| bus_wdata_o | output | 32 | Write data (full word) |
| bus_rdata_i | input | 32 | Read data, valid with `bus_ready_i` on a read |
| bus_ready_i | input | 1 | Slave accepts or completes the current request |

## Verification
A wrong step index shows at the bus on the very next request, as a wrong offset, direction or merge mask. A lost read value appears as missing bits in the next write, one access later. A mis-sized or mis-loaded delay counter shows only at the following request edge, as a gap shorter than the nanosecond minimum. A sequencer that fails to return to idle, or returns too early, shows within one cycle of the final completion as a mismatch of `busy` and `done` against the reference model, which is compared on every clock.

// File: rtl/lvds_bringup_pkg.sv
package lvds_bringup_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESP,
        ST_PAUSE
    } seq_state_e;

    typedef enum logic [1:0] {
        PAUSE_NONE,
        PAUSE_LONG,
        PAUSE_SHORT
    } pause_e;

    // One entry of the bring-up program.
    typedef struct packed {
        logic   write;   // 1 = write access
        logic   sel_b;   // 0 = first control word, 1 = second
        logic   merge;   // write data = last read OR mask
        word_t  mask;
        pause_e pause;   // wait after this access completes
    } step_t;

    localparam int unsigned STEP_IDX_W = 3;
    localparam int unsigned NUM_STEPS  = 7;
    localparam logic [STEP_IDX_W-1:0] LAST_STEP = STEP_IDX_W'(NUM_STEPS - 1);

    // Bias, regulator, clock and drive settings loaded by the first full write.
    localparam word_t CFG_A_LOAD    = 32'h3F71_0000;
    // Main-bias enable, set again as the final step.
    localparam word_t CFG_A_ENABLE  = 32'h0040_0000;
    // Lane initialisation groups.
    localparam word_t CFG_B_PREPARE = 32'h7C00_7C00;
    // Lane update groups.
    localparam word_t CFG_B_COMMIT  = 32'h001F_001F;

    // Nanoseconds to cycles: round up, then one cycle of margin.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned mhz);
        return (ns * mhz + 999) / 1000 + 1;
    endfunction

    function automatic step_t step_lookup(input logic [STEP_IDX_W-1:0] idx);
        step_t s;
        s = '{write: 1'b0, sel_b: 1'b0, merge: 1'b0, mask: '0, pause: PAUSE_NONE};
        case (idx)
            3'd0: s = '{write: 1'b1, sel_b: 1'b0, merge: 1'b0, mask: CFG_A_LOAD,    pause: PAUSE_LONG};
            3'd1: s = '{write: 1'b0, sel_b: 1'b1, merge: 1'b0, mask: '0,            pause: PAUSE_NONE};
            3'd2: s = '{write: 1'b1, sel_b: 1'b1, merge: 1'b1, mask: CFG_B_PREPARE, pause: PAUSE_SHORT};
            3'd3: s = '{write: 1'b0, sel_b: 1'b1, merge: 1'b0, mask: '0,            pause: PAUSE_NONE};
            3'd4: s = '{write: 1'b1, sel_b: 1'b1, merge: 1'b1, mask: CFG_B_COMMIT,  pause: PAUSE_NONE};
            3'd5: s = '{write: 1'b0, sel_b: 1'b0, merge: 1'b0, mask: '0,            pause: PAUSE_NONE};
            3'd6: s = '{write: 1'b1, sel_b: 1'b0, merge: 1'b1, mask: CFG_A_ENABLE,  pause: PAUSE_NONE};
            default: ;
        endcase
        return s;
    endfunction

    function automatic word_t merge_word(input step_t s, input word_t last_rd);
        return s.merge ? (last_rd | s.mask) : s.mask;
    endfunction

endpackage

// File: rtl/lvds_wait_timer.sv
module lvds_wait_timer
    import lvds_bringup_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 121,
    parameter int unsigned SHORT_CYC = 13
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  pause_e sel_i,
    output logic   expired_o
);
    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (sel_i == PAUSE_LONG) ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lvds_bus_port.sv
module lvds_bus_port
    import lvds_bringup_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic              cmd_we_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  word_t             cmd_wdata_i,
    output logic              rsp_valid_o,
    output word_t             rsp_data_o,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output word_t             wdata_o,
    input  word_t             rdata_i,
    input  logic              ready_i
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_o       <= 1'b0;
            we_o        <= 1'b0;
            addr_o      <= '0;
            wdata_o     <= '0;
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= 1'b0;
            if (req_o && ready_i) begin
                req_o       <= 1'b0;
                rsp_valid_o <= 1'b1;
                rsp_data_o  <= rdata_i;
            end else if (!req_o && cmd_valid_i) begin
                req_o   <= 1'b1;
                we_o    <= cmd_we_i;
                addr_o  <= cmd_addr_i;
                wdata_o <= cmd_wdata_i;
            end
        end
    end
endmodule

// File: rtl/lvds_phy_bringup.sv
module lvds_phy_bringup
    import lvds_bringup_pkg::*;
#(
    parameter int unsigned          CLK_MHZ    = 100,
    parameter int unsigned          ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]    REG_A_ADDR = 'h220,
    parameter logic [ADDR_W-1:0]    REG_B_ADDR = 'h224,
    parameter int unsigned          LONG_NS    = 1200,
    parameter int unsigned          SHORT_NS   = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic [31:0]       bus_rdata_i,
    input  logic              bus_ready_i
);
    localparam int unsigned WAIT_LONG_CYC  = ns_to_cycles(LONG_NS, CLK_MHZ);
    localparam int unsigned WAIT_SHORT_CYC = ns_to_cycles(SHORT_NS, CLK_MHZ);

    seq_state_e            state_q;
    logic [STEP_IDX_W-1:0] step_q;
    word_t                 rd_hold_q;
    logic                  done_q;

    step_t             cur;
    logic              cmd_valid;
    logic [ADDR_W-1:0] cmd_addr;
    word_t             cmd_wdata;
    logic              rsp_valid;
    word_t             rsp_data;
    logic              tmr_load;
    logic              tmr_expired;

    always_comb begin
        cur       = step_lookup(step_q);
        cmd_valid = (state_q == ST_ISSUE);
        cmd_addr  = cur.sel_b ? REG_B_ADDR : REG_A_ADDR;
        cmd_wdata = merge_word(cur, rd_hold_q);
        tmr_load  = (state_q == ST_RESP) && rsp_valid && (cur.pause != PAUSE_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            rd_hold_q <= '0;
            done_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_ISSUE;
                        step_q  <= '0;
                        done_q  <= 1'b0;
                    end
                end
                ST_ISSUE: state_q <= ST_RESP;
                ST_RESP: begin
                    if (rsp_valid) begin
                        if (!cur.write) rd_hold_q <= rsp_data;
                        if (cur.pause != PAUSE_NONE) begin
                            state_q <= ST_PAUSE;
                        end else if (step_q == LAST_STEP) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            step_q  <= STEP_IDX_W'(step_q + 1'b1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (tmr_expired) begin
                        step_q  <= STEP_IDX_W'(step_q + 1'b1);
                        state_q <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    lvds_wait_timer #(
        .LONG_CYC  (WAIT_LONG_CYC),
        .SHORT_CYC (WAIT_SHORT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .sel_i     (cur.pause),
        .expired_o (tmr_expired)
    );

    lvds_bus_port #(
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid),
        .cmd_we_i    (cur.write),
        .cmd_addr_i  (cmd_addr),
        .cmd_wdata_i (cmd_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .req_o       (bus_req_o),
        .we_o        (bus_we_o),
        .addr_o      (bus_addr_o),
        .wdata_o     (bus_wdata_o),
        .rdata_i     (bus_rdata_i),
        .ready_i     (bus_ready_i)
    );

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
endmodule

// File: rtl/lvds_phy_bringup_chk.sv
module lvds_phy_bringup_chk #(
    parameter int unsigned       ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_A_ADDR = 'h220,
    parameter logic [ADDR_W-1:0] REG_B_ADDR = 'h224,
    parameter int unsigned       LONG_CYC   = 121
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [31:0]       bus_wdata_o,
    input logic [31:0]       bus_rdata_i,
    input logic              bus_ready_i
);
    localparam int unsigned GAP_W = $clog2(LONG_CYC + 1) + 2;

    logic             rst_q;
    logic [GAP_W-1:0] gap_q;
    logic             last_wr_a_q;
    logic [31:0]      last_rd_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            gap_q       <= '0;
            last_wr_a_q <= 1'b0;
            last_rd_q   <= '0;
        end else if (bus_req_o && bus_ready_i) begin
            gap_q       <= '0;
            last_wr_a_q <= bus_we_o && (bus_addr_o == REG_A_ADDR);
            if (!bus_we_o) last_rd_q <= bus_rdata_i;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R8: request and its payload hold until ready
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_ready_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

    // R8: request drops after a completed transfer
    assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && bus_ready_i) |=> !bus_req_o);

    // R3: long settling gap before the read of the second word
    assert_long_wait_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_req_o) && last_wr_a_q && (bus_addr_o == REG_B_ADDR)) |->
            (gap_q > GAP_W'(LONG_CYC)));

    // R4: writes to the second word keep every bit of the preceding read
    assert_merge_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && bus_we_o && (bus_addr_o == REG_B_ADDR)) |->
            ((bus_wdata_o & last_rd_q) == last_rd_q));

    // R9: done and busy are exclusive
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R11: the cycle after reset is idle
    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!bus_req_o && !busy_o && !done_o));
endmodule

bind lvds_phy_bringup lvds_phy_bringup_chk #(
    .ADDR_W     (ADDR_W),
    .REG_A_ADDR (REG_A_ADDR),
    .REG_B_ADDR (REG_B_ADDR),
    .LONG_CYC   (WAIT_LONG_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ready_i (bus_ready_i)
);

// File: tb/lvds_phy_bringup_test.sv
module lvds_phy_bringup_test;
    localparam int          CLK_NS = 10;
    localparam int          ADDR_W = 12;
    localparam logic [11:0] ADR_A  = 12'h220;
    localparam logic [11:0] ADR_B  = 12'h224;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, bus_req_o, bus_we_o;
    logic [11:0] bus_addr_o;
    logic [31:0] bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        bus_ready_i = 1'b0;

    always #5 clk = ~clk;

    lvds_phy_bringup #(.CLK_MHZ(100), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
    );

    integer checks = 0;
    integer fails  = 0;
    integer cyc    = 0;

    // Expected program, taken from the requirements.
    logic        e_we    [7];
    logic [11:0] e_addr  [7];
    logic        e_merge [7];
    logic [31:0] e_mask  [7];
    integer      e_gap   [7];
    string       e_tag   [7];

    // Slave register contents and reference-model state.
    logic [31:0] reg_a, reg_b, last_rd;
    integer      lat = 0, wait_cnt = 0;
    bit          m_busy = 0, m_done = 0, fin_pend = 0;
    integer      m_ptr = 7, last_cmp = 0;
    logic        p_req = 0, p_ready = 0, p_we = 0, p_start = 0, p_rst = 1;
    logic [11:0] p_addr = '0;
    logic [31:0] p_wdata = '0, p_rdata = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=0x%08h expected=0x%08h", tag, cyc, act, exp);
        end
    endtask

    initial begin
        e_we[0]=1; e_addr[0]=ADR_A; e_merge[0]=0; e_mask[0]=32'h3F71_0000; e_gap[0]=0;    e_tag[0]="R2";
        e_we[1]=0; e_addr[1]=ADR_B; e_merge[1]=0; e_mask[1]=32'h0;         e_gap[1]=1200; e_tag[1]="R3";
        e_we[2]=1; e_addr[2]=ADR_B; e_merge[2]=1; e_mask[2]=32'h7C00_7C00; e_gap[2]=0;    e_tag[2]="R4";
        e_we[3]=0; e_addr[3]=ADR_B; e_merge[3]=0; e_mask[3]=32'h0;         e_gap[3]=120;  e_tag[3]="R5";
        e_we[4]=1; e_addr[4]=ADR_B; e_merge[4]=1; e_mask[4]=32'h001F_001F; e_gap[4]=0;    e_tag[4]="R6";
        e_we[5]=0; e_addr[5]=ADR_A; e_merge[5]=0; e_mask[5]=32'h0;         e_gap[5]=0;    e_tag[5]="R7";
        e_we[6]=1; e_addr[6]=ADR_A; e_merge[6]=1; e_mask[6]=32'h0040_0000; e_gap[6]=0;    e_tag[6]="R7";
    end

    // Reference model and slave, evaluated once per cycle at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (p_rst) begin
                m_busy = 0; m_done = 0; fin_pend = 0; m_ptr = 7; wait_cnt = 0;
            end else begin
                if (p_start && !m_busy) begin  // R1 / R10: accepted only when idle
                    m_busy = 1; m_done = 0; m_ptr = 0; last_cmp = cyc;
                end
                if (fin_pend) begin
                    m_busy = 0; m_done = 1; fin_pend = 0;
                end
                if (p_req && p_ready) begin
                    wait_cnt = 0;
                    if (!m_busy || m_ptr > 6) begin
                        chk(0, "R10 unexpected transfer", {20'b0, p_addr}, 32'h0);
                    end else begin
                        chk(p_addr == e_addr[m_ptr], e_tag[m_ptr], {20'b0, p_addr}, {20'b0, e_addr[m_ptr]});
                        chk(p_we == e_we[m_ptr], e_tag[m_ptr], {31'b0, p_we}, {31'b0, e_we[m_ptr]});
                        if (e_we[m_ptr]) begin
                            logic [31:0] exp_d;
                            exp_d = e_merge[m_ptr] ? (last_rd | e_mask[m_ptr]) : e_mask[m_ptr];
                            chk(p_wdata == exp_d, e_tag[m_ptr], p_wdata, exp_d);
                            if (p_addr == ADR_A) reg_a = p_wdata; else reg_b = p_wdata;
                            // The slave clears the enable bit after the first load,
                            // so the final read-modify-write has work to do.
                            if (m_ptr == 0) reg_a = reg_a & ~32'h0040_0000;
                        end else begin
                            last_rd = p_rdata;
                        end
                        last_cmp = cyc;
                        m_ptr++;
                        if (m_ptr == 7) fin_pend = 1;
                    end
                    chk(!bus_req_o, "R8 request not dropped", {31'b0, bus_req_o}, 32'h0);
                end
                if (bus_req_o && !p_req && !(p_req && p_ready)) begin
                    if (!m_busy || m_ptr > 6) begin
                        chk(0, "R10 request while idle", {20'b0, bus_addr_o}, 32'h0);
                    end else begin
                        chk((cyc - last_cmp) * CLK_NS >= e_gap[m_ptr],
                            (m_ptr == 1) ? "R3 long wait" : ((m_ptr == 3) ? "R5 short wait" : "R1 request gap"),
                            32'((cyc - last_cmp) * CLK_NS), 32'(e_gap[m_ptr]));
                        if (m_ptr == 0)
                            chk(bus_we_o && bus_addr_o == ADR_A, "R1 first access", {19'b0, bus_we_o, bus_addr_o}, {19'b0, 1'b1, ADR_A});
                    end
                end
                if (p_req && !p_ready) begin
                    chk(bus_req_o && bus_addr_o == p_addr && bus_we_o == p_we && bus_wdata_o == p_wdata,
                        "R8 hold", bus_wdata_o, p_wdata);
                end
            end
            chk(busy_o == m_busy, "R9 busy", {31'b0, busy_o}, {31'b0, m_busy});
            chk(done_o == m_done, "R9 done", {31'b0, done_o}, {31'b0, m_done});
            // Slave response
            if (bus_req_o && !p_rst) begin
                if (wait_cnt >= lat) begin
                    bus_ready_i = 1'b1;
                    bus_rdata_i = (bus_addr_o == ADR_A) ? reg_a : reg_b;
                end else begin
                    wait_cnt++;
                    bus_ready_i = 1'b0;
                end
            end else begin
                bus_ready_i = 1'b0;
                wait_cnt = 0;
            end
            p_req = bus_req_o; p_ready = bus_ready_i; p_addr = bus_addr_o; p_we = bus_we_o;
            p_wdata = bus_wdata_o; p_rdata = bus_rdata_i; p_start = start_i; p_rst = rst;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #2 start_i = 1'b1;
        @(posedge clk); #2 start_i = 1'b0;
    endtask

    task automatic pulse_rst();
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        integer n;
        n = 0;
        while (!done_o && n < 3000) begin @(negedge clk); n++; end
        chk(done_o, tag, {31'b0, done_o}, 32'h1);
    endtask

    task automatic idle(input integer n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        reg_a = 32'hC000_0005;
        reg_b = 32'h8000_0201;
        idle(3);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(!bus_req_o && !busy_o && !done_o, "R11 reset state",
            {29'b0, bus_req_o, busy_o, done_o}, 32'h0);

        // Run 1: zero-latency slave
        lat = 0;
        pulse_start();
        wait_done("R9 run1 done");
        chk(reg_b == 32'hFC1F_7E1F, "R6 run1 second word", reg_b, 32'hFC1F_7E1F);
        chk(reg_a == 32'h3F71_0000, "R7 run1 first word", reg_a, 32'h3F71_0000);
        idle(8);
        @(negedge clk);
        chk(done_o && !busy_o, "R9 done held", {30'b0, done_o, busy_o}, 32'h2);

        // Run 2: slow slave, extra starts while busy must be ignored
        lat = 3;
        reg_b = 32'h0000_8000;
        pulse_start();
        idle(30);
        pulse_start();   // R10
        idle(150);
        pulse_start();   // R10
        wait_done("R9 run2 done");
        chk(reg_b == 32'h7C1F_FC1F, "R10 run2 second word", reg_b, 32'h7C1F_FC1F);
        idle(200);
        @(negedge clk);
        chk(done_o && !busy_o && !bus_req_o, "R10 no second run",
            {29'b0, done_o, busy_o, bus_req_o}, 32'h4);

        // Run 3: reset during the long wait
        lat = 1;
        pulse_start();
        idle(60);
        pulse_rst();
        @(negedge clk);
        chk(!bus_req_o && !busy_o && !done_o, "R11 mid-run reset",
            {29'b0, bus_req_o, busy_o, done_o}, 32'h0);
        idle(200);
        @(negedge clk);
        chk(!bus_req_o && !busy_o && !done_o, "R11 stays idle",
            {29'b0, bus_req_o, busy_o, done_o}, 32'h0);

        // Run 4: full run after reset
        lat = 2;
        reg_b = 32'h0300_0000;
        pulse_start();
        @(negedge clk);
        chk(busy_o && !done_o, "R1 start accepted", {30'b0, busy_o, done_o}, 32'h2);
        wait_done("R9 run4 done");
        chk(reg_b == 32'h7F1F_7C1F, "R4 run4 second word", reg_b, 32'h7F1F_7C1F);
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule